// File: doc/BRIEF.md
# Descriptor-Chained Transmit DMA Channel

This block is one transmit channel that streams packet bytes out of a small internal packet RAM, steered by a chain of buffer descriptors kept in an internal descriptor RAM. Software fills both RAMs through one word-wide configuration port. It then points the channel at the first descriptor by writing the head register. The channel walks the chain one descriptor at a time. For each one it emits the referenced bytes on a byte-wide valid/ready stream, then hands the descriptor back to software. It does this by clearing the descriptor's ownership flag and recording the descriptor's address in the completion register.

Each descriptor takes four consecutive words. A packet may span several descriptors: the start and end flags in each mode word mark where the packet begins and where it ends. When the last linked descriptor is done, the channel marks it end-of-queue and the head register drops to zero. Software that links a new descriptor behind a chain that has already stopped must restart the channel by writing the new address to the head register. A descriptor of length zero is handed back without emitting bytes. A soft reset bit returns the channel registers to their idle values and leaves both RAMs intact.

Top module: `bd_tx_dma`

## Requirements
- R1: After reset, the control, head, completion and soft-reset registers read 0 and `tx_valid` is low.
- R2: The configuration port selects a space with `cfg_sel`: 0 is registers, 1 is descriptor RAM words, 2 is packet RAM words. The register offsets are 0 for control, 1 for head, 2 for completion and 3 for soft reset. A descriptor pointer is a descriptor-RAM word address that is a multiple of 4. The word at +0 holds the next pointer, +1 the byte address of the buffer, +2 the buffer length (bits 10:0), and +3 the mode word. The channel sends exactly that many bytes from consecutive packet RAM addresses, which wrap at the RAM size, and then follows the next pointer. A next pointer of 0 ends the chain, and the head register then reads 0.
- R3: A packet RAM word write at word index i stores bits 7:0 at byte 4i, 15:8 at 4i+1, 23:16 at 4i+2 and 31:24 at 4i+3.
- R4: `tx_first` is high only on the first byte of a descriptor whose mode bit 31 (start) is set. `tx_last` is high only on the final byte of a descriptor whose mode bit 30 (end) is set. Both can fall within one descriptor.
- R5: After the final byte of a descriptor is accepted, the channel rewrites its mode word with bit 29 (owner) cleared. It sets bit 28 (end-of-queue) when the next pointer is 0. All other bits are left unchanged.
- R6: A fetched descriptor whose owner bit is 0 emits no bytes and is not rewritten, and the head register returns to 0.
- R7: Control bit 0 enables the channel. While it is 0, a head write is stored but no fetch begins. Setting it later starts the stored chain.
- R8: A head write while the channel is fetching, sending or handing back a descriptor is ignored.
- R9: Linking a new descriptor behind a chain that has already ended starts nothing. A following head write with that descriptor's address sends it.
- R10: The completion register takes the address of each descriptor the channel hands back. A software write overwrites it, and the new value reads back.
- R11: Writing 1 to soft-reset bit 0 clears the enable, head and completion registers and stops the stream on the next cycle. The bit reads 1 for 4 cycles and then 0. RAM contents are kept.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_first` and `tx_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Space select: registers, descriptor RAM, packet RAM |
| cfg_addr | input | CFG_AW | Word address within the selected space |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for registers and descriptor RAM (0 for packet RAM) |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Packet byte |
| tx_first | output | 1 | First byte of a packet |
| tx_last | output | 1 | Final byte of a packet |

## Verification
The stream is exercised with a sink that is always ready, with a pseudo-random ready pattern, and with a fully stalled sink. These separate pure ordering errors from handshake mishandling and from data that drifts while a byte is held. The chains cover a single-descriptor packet carrying both markers, and a three-descriptor packet with a middle descriptor that has no marker and a buffer that wraps the packet RAM. Odd byte addresses check the byte lanes. Further scenarios cover a descriptor without ownership, a tail link behind an ended chain, head writes while the channel is disabled and while it is busy, and a soft reset in the middle of a packet. Together they show which path changed the head and completion registers.

// File: rtl/bd_pkg.sv
package bd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_SEND = 2'd2,
        ST_DONE = 2'd3
    } bd_state_e;

    // mode word flag positions (decoded by software as well)
    localparam int MODE_SOP = 31;
    localparam int MODE_EOP = 30;
    localparam int MODE_OWN = 29;
    localparam int MODE_EOQ = 28;
    localparam int LEN_W    = 11;

    // word offsets inside one descriptor
    localparam logic [1:0] W_NEXT = 2'd0;
    localparam logic [1:0] W_BUF  = 2'd1;
    localparam logic [1:0] W_LEN  = 2'd2;
    localparam logic [1:0] W_MODE = 2'd3;

    // configuration spaces and register offsets
    localparam logic [1:0] SEL_REG  = 2'd0;
    localparam logic [1:0] SEL_DESC = 2'd1;
    localparam logic [1:0] SEL_PKT  = 2'd2;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_HEAD = 2'd1;
    localparam logic [1:0] REG_DONE = 2'd2;
    localparam logic [1:0] REG_SRST = 2'd3;

endpackage

// File: rtl/bd_desc_ram.sv
module bd_desc_ram #(
    parameter int DESC_WORDS = 64,
    localparam int DPW = $clog2(DESC_WORDS)
) (
    input  logic                  clk,
    input  logic                  sw_we,
    input  logic [DPW-1:0]        sw_addr,
    input  logic [31:0]           sw_wdata,
    output logic [31:0]           sw_rdata,
    input  logic                  hw_we,
    input  logic [DPW-1:0]        hw_addr,
    input  logic [31:0]           hw_wdata,
    input  logic [DPW-1:0]        hw_ptr,
    output logic [3:0][31:0]      hw_rdata
);

    logic [31:0] mem [DESC_WORDS];

    // engine write-back wins over a software write to the same word
    always_ff @(posedge clk) begin
        if (hw_we) begin
            mem[hw_addr] <= hw_wdata;
        end
        if (sw_we && !(hw_we && hw_addr == sw_addr)) begin
            mem[sw_addr] <= sw_wdata;
        end
    end

    assign sw_rdata = mem[sw_addr];

    for (genvar k = 0; k < 4; k++) begin : g_slot_rd
        assign hw_rdata[k] = mem[{hw_ptr[DPW-1:2], 2'(k)}];
    end

endmodule

// File: rtl/bd_pkt_ram.sv
module bd_pkt_ram #(
    parameter int PKT_BYTES = 256,
    localparam int PBW = $clog2(PKT_BYTES)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [PBW-3:0]  waddr,
    input  logic [31:0]     wdata,
    input  logic [PBW-1:0]  raddr,
    output logic [7:0]      rbyte
);

    logic [7:0] mem [PKT_BYTES];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int k = 0; k < 4; k++) begin
                mem[{waddr, 2'(k)}] <= wdata[8*k +: 8];
            end
        end
    end

    assign rbyte = mem[raddr];

endmodule

// File: rtl/bd_tx_engine.sv
module bd_tx_engine
    import bd_pkg::*;
#(
    parameter int DPW         = 6,
    parameter int PBW         = 8,
    parameter int SRST_CYCLES = 4,
    localparam int SCW = $clog2(SRST_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic [DPW-1:0]   rd_ptr,
    input  logic [3:0][31:0] dw,
    output logic             wb_we,
    output logic [DPW-1:0]   wb_addr,
    output logic [31:0]      wb_data,
    output logic [PBW-1:0]   pk_addr,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic             tx_first,
    output logic             tx_last
);

    typedef struct packed {
        bd_state_e        st;
        logic             en;
        logic [DPW-1:0]   head;
        logic [DPW-1:0]   done;
        logic [DPW-1:0]   nxt;
        logic [PBW-1:0]   bptr;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] cnt;
        logic [31:0]      mode;
        logic             srst;
        logic [SCW-1:0]   scnt;
    } eng_t;

    localparam eng_t ENG_RST = '0;

    eng_t q, d;

    logic last_beat;
    assign last_beat = (q.cnt == q.len - 1'b1);

    always_comb begin
        d       = q;
        wb_we   = 1'b0;
        wb_addr = {q.head[DPW-1:2], W_MODE};
        wb_data = q.mode;
        wb_data[MODE_OWN] = 1'b0;
        if (q.nxt == '0) begin
            wb_data[MODE_EOQ] = 1'b1;
        end

        if (q.srst) begin
            d      = ENG_RST;
            d.srst = (q.scnt != SCW'(SRST_CYCLES - 1));
            d.scnt = q.scnt + 1'b1;
        end else if (reg_we && reg_addr == REG_SRST && reg_wdata[0]) begin
            d      = ENG_RST;
            d.srst = 1'b1;
        end else begin
            if (reg_we) begin
                case (reg_addr)
                    REG_CTRL: d.en = reg_wdata[0];
                    REG_HEAD: if (q.st == ST_IDLE) d.head = reg_wdata[DPW-1:0];
                    REG_DONE: d.done = reg_wdata[DPW-1:0];
                    default: ;
                endcase
            end
            case (q.st)
                ST_IDLE: begin
                    if (q.en && q.head != '0) begin
                        d.st = ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    d.nxt  = dw[W_NEXT][DPW-1:0];
                    d.bptr = dw[W_BUF][PBW-1:0];
                    d.len  = dw[W_LEN][LEN_W-1:0];
                    d.mode = dw[W_MODE];
                    d.cnt  = '0;
                    if (q.head == '0) begin
                        d.st = ST_IDLE;
                    end else if (!dw[W_MODE][MODE_OWN]) begin
                        d.head = '0;
                        d.st   = ST_IDLE;
                    end else if (dw[W_LEN][LEN_W-1:0] == '0) begin
                        d.st = ST_DONE;
                    end else begin
                        d.st = ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (tx_ready) begin
                        if (last_beat) begin
                            d.st = ST_DONE;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_DONE: begin
                    wb_we  = 1'b1;
                    d.done = q.head;
                    d.head = q.nxt;
                    d.st   = ST_IDLE;
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= ENG_RST;
        end else begin
            q <= d;
        end
    end

    assign rd_ptr   = q.head;
    assign pk_addr  = q.bptr + PBW'(q.cnt);
    assign tx_valid = (q.st == ST_SEND);
    assign tx_first = tx_valid && q.mode[MODE_SOP] && (q.cnt == '0);
    assign tx_last  = tx_valid && q.mode[MODE_EOP] && last_beat;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL: reg_rdata[0]       = q.en;
            REG_HEAD: reg_rdata[DPW-1:0] = q.head;
            REG_DONE: reg_rdata[DPW-1:0] = q.done;
            default:  reg_rdata[0]       = q.srst;
        endcase
    end

    logic unused_eng;
    assign unused_eng = ^{reg_wdata[31:DPW], dw[W_NEXT][31:DPW], dw[W_BUF][31:PBW],
                          dw[W_LEN][31:LEN_W]};

endmodule

// File: rtl/bd_tx_dma.sv
module bd_tx_dma
    import bd_pkg::*;
#(
    parameter int DESC_WORDS  = 64,
    parameter int PKT_BYTES   = 256,
    parameter int CFG_AW      = 8,
    parameter int SRST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_first,
    output logic              tx_last
);

    localparam int DPW = $clog2(DESC_WORDS);
    localparam int PBW = $clog2(PKT_BYTES);

    logic [31:0]      eng_rdata;
    logic [31:0]      desc_rdata;
    logic [DPW-1:0]   eng_head;
    logic [3:0][31:0] eng_dw;
    logic             eng_wb_we;
    logic [DPW-1:0]   eng_wb_addr;
    logic [31:0]      eng_wb_data;
    logic [PBW-1:0]   eng_pk_addr;

    bd_desc_ram #(.DESC_WORDS(DESC_WORDS)) i_dram (
        .clk      (clk),
        .sw_we    (cfg_we && cfg_sel == SEL_DESC),
        .sw_addr  (cfg_addr[DPW-1:0]),
        .sw_wdata (cfg_wdata),
        .sw_rdata (desc_rdata),
        .hw_we    (eng_wb_we),
        .hw_addr  (eng_wb_addr),
        .hw_wdata (eng_wb_data),
        .hw_ptr   (eng_head),
        .hw_rdata (eng_dw)
    );

    bd_pkt_ram #(.PKT_BYTES(PKT_BYTES)) i_pram (
        .clk   (clk),
        .we    (cfg_we && cfg_sel == SEL_PKT),
        .waddr (cfg_addr[PBW-3:0]),
        .wdata (cfg_wdata),
        .raddr (eng_pk_addr),
        .rbyte (tx_data)
    );

    bd_tx_engine #(.DPW(DPW), .PBW(PBW), .SRST_CYCLES(SRST_CYCLES)) i_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (cfg_we && cfg_sel == SEL_REG),
        .reg_addr  (cfg_addr[1:0]),
        .reg_wdata (cfg_wdata),
        .reg_rdata (eng_rdata),
        .rd_ptr    (eng_head),
        .dw        (eng_dw),
        .wb_we     (eng_wb_we),
        .wb_addr   (eng_wb_addr),
        .wb_data   (eng_wb_data),
        .pk_addr   (eng_pk_addr),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_first  (tx_first),
        .tx_last   (tx_last)
    );

    always_comb begin
        case (cfg_sel)
            SEL_REG:  cfg_rdata = eng_rdata;
            SEL_DESC: cfg_rdata = desc_rdata;
            default:  cfg_rdata = '0;
        endcase
    end

    logic unused_top;
    assign unused_top = ^cfg_addr;

endmodule

// File: rtl/bd_tx_dma_chk.sv
module bd_tx_dma_chk #(
    parameter int DPW = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_we,
    input logic [1:0]     cfg_sel,
    input logic [1:0]     cfg_addr_lo,
    input logic           cfg_wbit0,
    input logic           tx_valid,
    input logic           tx_ready,
    input logic [7:0]     tx_data,
    input logic           tx_first,
    input logic           tx_last,
    input logic [DPW-1:0] head,
    input logic           wb_we
);

    logic srst_wr;
    assign srst_wr = cfg_we && cfg_sel == 2'd0 && cfg_addr_lo == 2'd3 && cfg_wbit0;

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && !cfg_we |=>
            tx_valid && $stable(tx_data) && $stable(tx_first) && $stable(tx_last));

    assert_first_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_first |-> !$past(tx_valid && tx_ready));

    assert_handback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_last && !srst_wr |=> wb_we && !tx_valid);

    assert_fetch_needs_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(head) != '0);

    assert_srst_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        srst_wr |=> !tx_valid && head == '0);

endmodule

bind bd_tx_dma bd_tx_dma_chk #(.DPW(DPW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_addr_lo (cfg_addr[1:0]),
    .cfg_wbit0   (cfg_wdata[0]),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .tx_first    (tx_first),
    .tx_last     (tx_last),
    .head        (eng_head),
    .wb_we       (eng_wb_we)
);

// File: tb/test_bd_tx_dma.sv
module test_bd_tx_dma;

    localparam logic [31:0] F_SOP = 32'h8000_0000;
    localparam logic [31:0] F_EOP = 32'h4000_0000;
    localparam logic [31:0] F_OWN = 32'h2000_0000;
    localparam logic [31:0] F_EOQ = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [7:0]  cfg_addr = 8'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_first;
    logic        tx_last;

    always #5 clk = ~clk;

    bd_tx_dma i_bd_tx_dma (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_first(tx_first), .tx_last(tx_last)
    );

    int checks = 0;
    int errors = 0;
    int rmode  = 0;
    bit done_flag = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [9:0]  exp_q [$];
    logic [9:0]  e;
    logic [7:0]  shadow [256];
    logic [31:0] dimg [64];
    logic [31:0] rv;

    // reference stream model: drive ready, then compare the beat that the next edge accepts
    always @(negedge clk) begin
        case (rmode)
            0: tx_ready = 1'b1;
            1: begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                tx_ready = lfsr[0] | lfsr[3];
            end
            default: tx_ready = 1'b0;
        endcase
        if (rst_n && tx_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2: actual unexpected byte %02h expected no output", tx_data);
            end else if (tx_ready) begin
                e = exp_q.pop_front();
                checks++;
                if ({tx_first, tx_last, tx_data} !== e) begin
                    errors++;
                    $display("FAIL R3/R4: actual first=%0b last=%0b data=%02h expected first=%0b last=%0b data=%02h",
                             tx_first, tx_last, tx_data, e[9], e[8], e[7:0]);
                end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [1:0] s, input int a, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_addr = a[7:0]; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic [1:0] s, input int a, output logic [31:0] v);
        @(negedge clk);
        cfg_sel = s; cfg_addr = a[7:0];
        #1 v = cfg_rdata;
    endtask

    task automatic make_desc(input int p, input int nx, input int b, input int len, input logic [31:0] fl);
        dimg[p] = nx; dimg[p+1] = b; dimg[p+2] = len; dimg[p+3] = fl | 32'(len);
        for (int k = 0; k < 4; k++) cfg_wr(2'd1, p + k, dimg[p+k]);
    endtask

    task automatic expect_chain(input int start);
        int p;
        p = start & 63;
        while (p != 0) begin
            logic [31:0] m;
            int len, b;
            m = dimg[p+3];
            if (!m[29]) break;
            len = int'(dimg[p+2][10:0]);
            b   = int'(dimg[p+1][7:0]);
            for (int i = 0; i < len; i++)
                exp_q.push_back({m[31] && i == 0, m[30] && i == len - 1, shadow[(b + i) % 256]});
            m = m & ~F_OWN;
            if ((dimg[p] & 63) == 0) m = m | F_EOQ;
            dimg[p+3] = m;
            p = int'(dimg[p] & 63);
        end
    endtask

    task automatic wait_idle(input string tag);
        for (int i = 0; i < 2000; i++) begin
            cfg_rd(2'd0, 1, rv);
            if (rv == 0 && exp_q.size() == 0) break;
        end
        check({tag, " R2 head zero at chain end"}, rv, 32'd0);
        check({tag, " R2 all bytes sent"}, exp_q.size(), 32'd0);
    endtask

    task automatic report;
        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected completion");
        report();
        $finish;
    end

    initial begin
        logic [7:0] s0, s1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset values
        for (int r = 0; r < 4; r++) begin
            cfg_rd(2'd0, r, rv);
            check($sformatf("R1 reg %0d", r), rv, 32'd0);
        end
        check("R1 tx_valid", {31'd0, tx_valid}, 32'd0);

        // R3: fill packet RAM through word writes
        for (int i = 0; i < 256; i++) shadow[i] = 8'(i * 37 + 11);
        for (int w = 0; w < 64; w++)
            cfg_wr(2'd2, w, {shadow[4*w+3], shadow[4*w+2], shadow[4*w+1], shadow[4*w]});

        // R7: head stored while disabled, nothing fetched
        make_desc(4, 0, 3, 5, F_SOP | F_EOP | F_OWN);
        cfg_wr(2'd0, 1, 32'd4);
        repeat (20) @(negedge clk);
        cfg_rd(2'd0, 1, rv);
        check("R7 head kept while disabled", rv, 32'd4);
        expect_chain(4);
        cfg_wr(2'd0, 0, 32'd1);
        wait_idle("single");
        cfg_rd(2'd1, 7, rv);
        check("R5 owner cleared, eoq set", rv, dimg[7]);
        cfg_rd(2'd0, 2, rv);
        check("R10 completion address", rv, 32'd4);

        // R2/R4: three-descriptor packet with backpressure and buffer wrap
        rmode = 1;
        make_desc(8, 12, 40, 7, F_SOP | F_OWN);
        make_desc(12, 16, 101, 1, F_OWN);
        make_desc(16, 0, 250, 9, F_EOP | F_OWN);
        expect_chain(8);
        cfg_wr(2'd0, 1, 32'd8);
        wait_idle("chain");
        for (int p = 8; p <= 16; p += 4) begin
            cfg_rd(2'd1, p + 3, rv);
            check($sformatf("R5 mode word of %0d", p), rv, dimg[p+3]);
        end
        cfg_rd(2'd0, 2, rv);
        check("R10 completion is last descriptor", rv, 32'd16);

        // R9: tail link after end of queue needs a head write
        rmode = 0;
        make_desc(20, 0, 61, 4, F_SOP | F_EOP | F_OWN);
        dimg[16] = 20;
        cfg_wr(2'd1, 16, 32'd20);
        repeat (10) @(negedge clk);
        cfg_rd(2'd0, 1, rv);
        check("R9 no restart by link alone", rv, 32'd0);
        expect_chain(20);
        cfg_wr(2'd0, 1, 32'd20);
        wait_idle("append");
        cfg_rd(2'd1, 23, rv);
        check("R9 appended descriptor handed back", rv, dimg[23]);

        // R6: descriptor not owned by the channel
        make_desc(24, 0, 0, 6, F_SOP | F_EOP);
        cfg_wr(2'd0, 1, 32'd24);
        repeat (10) @(negedge clk);
        cfg_rd(2'd0, 1, rv);
        check("R6 head back to zero", rv, 32'd0);
        cfg_rd(2'd1, 27, rv);
        check("R6 mode untouched", rv, dimg[27]);

        // R10: software acknowledge overwrites completion
        cfg_wr(2'd0, 2, 32'd17);
        cfg_rd(2'd0, 2, rv);
        check("R10 software write reads back", rv, 32'd17);

        // R8/R12: head write while busy, stalled sink
        rmode = 2;
        make_desc(32, 0, 90, 3, F_SOP | F_EOP | F_OWN);
        make_desc(28, 0, 10, 6, F_SOP | F_EOP | F_OWN);
        expect_chain(28);
        cfg_wr(2'd0, 1, 32'd28);
        repeat (5) @(negedge clk);
        cfg_wr(2'd0, 1, 32'd32);
        cfg_rd(2'd0, 1, rv);
        check("R8 busy head write ignored", rv, 32'd28);
        @(negedge clk); s0 = tx_data;
        @(negedge clk); s1 = tx_data;
        check("R12 held byte stable", {24'd0, s1}, {24'd0, s0});
        check("R12 held byte value", {23'd0, tx_valid, s1}, {23'd0, 1'b1, exp_q[0][7:0]});
        rmode = 0;
        wait_idle("busy");
        cfg_rd(2'd0, 2, rv);
        check("R8 only first descriptor done", rv, 32'd28);

        // R11: soft reset mid-packet
        rmode = 2;
        make_desc(36, 0, 0, 8, F_SOP | F_EOP | F_OWN);
        expect_chain(36);
        dimg[39] = F_SOP | F_EOP | F_OWN | 32'd8;
        cfg_wr(2'd0, 1, 32'd36);
        repeat (5) @(negedge clk);
        cfg_wr(2'd0, 3, 32'd1);
        exp_q.delete();
        cfg_rd(2'd0, 3, rv);
        check("R11 reset bit reads 1", rv, 32'd1);
        repeat (6) @(negedge clk);
        cfg_rd(2'd0, 3, rv);
        check("R11 reset bit self-clears", rv, 32'd0);
        cfg_rd(2'd0, 0, rv);
        check("R11 enable cleared", rv, 32'd0);
        cfg_rd(2'd0, 1, rv);
        check("R11 head cleared", rv, 32'd0);
        cfg_rd(2'd0, 2, rv);
        check("R11 completion cleared", rv, 32'd0);
        check("R11 stream stopped", {31'd0, tx_valid}, 32'd0);
        cfg_rd(2'd1, 39, rv);
        check("R11 descriptor RAM kept", rv, dimg[39]);
        rmode = 0;
        expect_chain(36);
        cfg_wr(2'd0, 0, 32'd1);
        cfg_wr(2'd0, 1, 32'd36);
        wait_idle("after reset");

        report();
        $finish;
    end

endmodule